// File: doc/BRIEF.md
# Asynchronous Static Memory Controller with Byte Lanes

This block lets a clocked system issue single-word reads and writes to an external asynchronous static memory. The memory has 17 address bits, so it holds 131,072 words of 16 bits. It is controlled by active-low strobes: a select, a read-output enable, a write strobe and one enable for each byte lane. The host side is a valid/ready request port that carries an address, write data, a per-byte mask and a read/write flag. Read results come back on a one-cycle response strobe together with the captured word.

Each nanosecond minimum is a parameter. It is turned into a clock-cycle count by rounding up against the clock period. A write holds the select, the write strobe and the chosen lane enables low together for the whole counted pulse. The address and the write data stay fixed throughout that pulse. A short recovery phase then pads the cycle out to the full write-cycle minimum.

A read holds the select, the output enable and the chosen lane enables low for the counted access time. The word is sampled on the edge that ends that interval. The shared data bus is split at the pad into an outgoing word, an incoming word and a drive-enable. After any read, the drive-enable stays off until the memory outputs are sure to have released the bus.

Top module: `sram_async_ctrl`

## Requirements
- R1: During reset and whenever `req_ready` is high, `mem_cs_n`, `mem_oe_n`, `mem_we_n` and both `mem_lane_n` bits are high, and `mem_dq_oe` is low. `req_ready` is high after reset.
- R2: `req_mask` bit 0 selects data bits 7:0 and drives `mem_lane_n[0]`. Bit 1 selects bits 15:8 and drives `mem_lane_n[1]`. A write changes only the selected bytes of the addressed word, and a lane whose mask bit is clear keeps its old contents.
- R3: A write holds `mem_cs_n`, `mem_we_n` and the selected lane enables low, with `mem_dq_oe` high, for exactly ceil(100 ns / period) consecutive cycles (5 at 20 ns). `mem_addr` and `mem_dq_out` do not change during that pulse. `mem_we_n` and `mem_oe_n` are never low together.
- R4: Two successive falls of `mem_cs_n` are at least ceil(120 ns / period) cycles apart (6 at 20 ns).
- R5: A read holds `mem_cs_n`, `mem_oe_n` and the selected lane enables low, with `mem_we_n` high, for ceil(max(120, 80) ns / period) cycles (6). The bus is sampled on the edge that ends this interval. `rsp_valid` is high for exactly one cycle after that edge, with the data. A byte lane that was not selected reads as zero.
- R6: `mem_dq_oe` is never high while the memory may be driving the bus. That covers the read access itself and at least ceil(45 ns / period) cycles (3) after the release of `mem_oe_n`.
- R7: A request is taken only on a clock edge where both `req_valid` and `req_ready` are high. `req_ready` then stays low for 6 cycles after a write and for 9 cycles after a read (access plus turnaround).
- R8: Asserting `rst_n` low in the middle of a write raises every memory strobe and drops `mem_dq_oe` at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to `clk` |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Byte-lane select, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rsp_valid | output | 1 | One-cycle read-data strobe |
| rsp_rdata | output | 16 | Captured read word, with unselected lanes zero |
| mem_addr | output | 17 | Memory address |
| mem_cs_n | output | 1 | Memory select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_lane_n | output | 2 | Byte-lane enables, active low, bit 0 = low byte |
| mem_dq_out | output | 16 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_out` on the shared bus |
| mem_dq_in | input | 16 | Data seen on the shared bus |

## Verification
The assertions assume three things about the inputs. First, `rst_n` is released away from a clock edge. Second, the memory only drives `mem_dq_in` under the strobe conditions of R5 and R6. Third, the host keeps a request steady until it is accepted. The bench meets all three with a behavioural memory model. That model returns a junk pattern until the counted access time has passed and on every lane whose enable is high. It also keeps claiming the bus for three cycles after each release, and it flags any overlap with `mem_dq_oe`. The host tasks hold `req_valid` and its fields constant until the edge where `req_ready` is seen high.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_PULSE,
    ST_WR_RECOVER,
    ST_RD_ACCESS,
    ST_RD_RELEASE
  } ctl_state_t;

  function automatic int unsigned ns_to_cycles(input int unsigned ns, input int unsigned period_ns);
    return (ns + period_ns - 1) / period_ns;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);

  // a phase is never restarted before its count has run out
  AST_LOAD_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> expired); // R4

endmodule

// File: rtl/sram_lane_gate.sv
module sram_lane_gate #(
  parameter int unsigned LANES = 2
) (
  input  logic             active,
  input  logic [LANES-1:0] sel,
  output logic [LANES-1:0] lane_n
);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_n[l] = ~(active & sel[l]);
  end

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
  parameter int unsigned DATA_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                capture,
  input  logic [DATA_W/8-1:0] sel,
  input  logic [DATA_W-1:0]   dq_in,
  output logic                valid,
  output logic [DATA_W-1:0]   rdata
);

  localparam int unsigned LANES = DATA_W / 8;

  logic [DATA_W-1:0] rdata_d;
  logic              valid_q;

  for (genvar l = 0; l < LANES; l++) begin : g_mask
    assign rdata_d[l*8 +: 8] = sel[l] ? dq_in[l*8 +: 8] : 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (capture) begin
      rdata <= rdata_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= capture;
    end
  end

  assign valid = valid_q;

  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid); // R5

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W           = 17,
  parameter int unsigned DATA_W           = 16,
  parameter int unsigned CLK_PERIOD_NS    = 20,
  parameter int unsigned T_WE_PULSE_NS    = 85,
  parameter int unsigned T_SEL_TO_END_NS  = 100,
  parameter int unsigned T_ADDR_TO_END_NS = 100,
  parameter int unsigned T_DATA_SETUP_NS  = 60,
  parameter int unsigned T_WCYCLE_NS      = 120,
  parameter int unsigned T_RCYCLE_NS      = 120,
  parameter int unsigned T_OE_ACCESS_NS   = 80,
  parameter int unsigned T_RELEASE_HZ_NS  = 45
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic [DATA_W/8-1:0] req_mask,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic                mem_cs_n,
  output logic                mem_oe_n,
  output logic                mem_we_n,
  output logic [DATA_W/8-1:0] mem_lane_n,
  output logic [DATA_W-1:0]   mem_dq_out,
  output logic                mem_dq_oe,
  input  logic [DATA_W-1:0]   mem_dq_in
);

  localparam int unsigned LANES    = DATA_W / 8;
  localparam int unsigned WR_CYC   = max2(max2(ns_to_cycles(T_WE_PULSE_NS, CLK_PERIOD_NS),
                                               ns_to_cycles(T_SEL_TO_END_NS, CLK_PERIOD_NS)),
                                          max2(ns_to_cycles(T_ADDR_TO_END_NS, CLK_PERIOD_NS),
                                               ns_to_cycles(T_DATA_SETUP_NS, CLK_PERIOD_NS)));
  localparam int unsigned WC_CYC   = ns_to_cycles(T_WCYCLE_NS, CLK_PERIOD_NS);
  localparam int unsigned WREC_CYC = (WC_CYC > WR_CYC) ? WC_CYC - WR_CYC : 1;
  localparam int unsigned RD_CYC   = max2(ns_to_cycles(T_RCYCLE_NS, CLK_PERIOD_NS),
                                          ns_to_cycles(T_OE_ACCESS_NS, CLK_PERIOD_NS));
  localparam int unsigned HZ_CYC   = max2(ns_to_cycles(T_RELEASE_HZ_NS, CLK_PERIOD_NS), 1);
  localparam int unsigned MAX_CYC  = max2(max2(WR_CYC, WREC_CYC), max2(RD_CYC, HZ_CYC));
  localparam int unsigned CNT_W    = $clog2(MAX_CYC + 1);

  ctl_state_t          state_q, state_d;
  logic                accept;
  logic                tmr_load;
  logic [CNT_W-1:0]    tmr_val;
  logic                tmr_done;
  logic                capture;
  logic                sel_active;
  logic [ADDR_W-1:0]   addr_q;
  logic [DATA_W-1:0]   wdata_q;
  logic [LANES-1:0]    mask_q;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;

  // next-state process
  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    capture  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          tmr_load = 1'b1;
          if (req_write) begin
            state_d = ST_WR_PULSE;
            tmr_val = CNT_W'(WR_CYC - 1);
          end else begin
            state_d = ST_RD_ACCESS;
            tmr_val = CNT_W'(RD_CYC - 1);
          end
        end
      end
      ST_WR_PULSE: begin
        if (tmr_done) begin
          state_d  = ST_WR_RECOVER;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(WREC_CYC - 1);
        end
      end
      ST_WR_RECOVER: begin
        if (tmr_done) state_d = ST_IDLE;
      end
      ST_RD_ACCESS: begin
        if (tmr_done) begin
          state_d  = ST_RD_RELEASE;
          capture  = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(HZ_CYC - 1);
        end
      end
      ST_RD_RELEASE: begin
        if (tmr_done) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // state register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  // request holding registers, loaded only on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      mask_q  <= req_mask;
    end
  end

  sram_phase_timer #(.CNT_W(CNT_W)) i_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_done)
  );

  // strobes decoded from the registered state only
  assign sel_active = (state_q == ST_WR_PULSE) || (state_q == ST_RD_ACCESS);
  assign mem_cs_n   = ~sel_active;
  assign mem_we_n   = (state_q != ST_WR_PULSE);
  assign mem_oe_n   = (state_q != ST_RD_ACCESS);
  assign mem_dq_oe  = (state_q == ST_WR_PULSE);
  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;

  sram_lane_gate #(.LANES(LANES)) i_lanes (
    .active (sel_active),
    .sel    (mask_q),
    .lane_n (mem_lane_n)
  );

  sram_rd_capture #(.DATA_W(DATA_W)) i_capture (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (capture),
    .sel     (mask_q),
    .dq_in   (mem_dq_in),
    .valid   (rsp_valid),
    .rdata   (rsp_rdata)
  );

  AST_IDLE_LINES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_cs_n && mem_oe_n && mem_we_n && (&mem_lane_n) && !mem_dq_oe)); // R1

  AST_WE_OE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_we_n && !mem_oe_n)); // R3

  AST_WR_PULSE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && !$past(mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out))); // R3

  AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_dq_oe); // R6

  AST_RELEASE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> (!mem_dq_oe ##1 !mem_dq_oe)); // R6

  AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $rose(mem_oe_n)); // R5

endmodule

// File: tb/test_sram_async_ctrl.sv
module test_sram_async_ctrl;

  localparam int PERIOD = 20;
  localparam int WR_CYC = (100 + PERIOD - 1) / PERIOD;
  localparam int WC_CYC = (120 + PERIOD - 1) / PERIOD;
  localparam int RD_CYC = (120 + PERIOD - 1) / PERIOD;
  localparam int HZ_CYC = (45 + PERIOD - 1) / PERIOD;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic        req_write;
  logic [16:0] req_addr;
  logic [15:0] req_wdata;
  logic [1:0]  req_mask;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic [16:0] mem_addr;
  logic        mem_cs_n;
  logic        mem_oe_n;
  logic        mem_we_n;
  logic [1:0]  mem_lane_n;
  logic [15:0] mem_dq_out;
  logic        mem_dq_oe;
  logic [15:0] mem_dq_in;

  int errors = 0;
  int checks = 0;

  sram_async_ctrl i_sram_async_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_lane_n(mem_lane_n), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  initial begin
    clk = 1'b0;
    forever #(PERIOD / 2) clk = ~clk;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // ---------------- behavioural memory model ----------------
  logic [15:0] mdl_mem [logic [16:0]];
  logic [15:0] exp_mem [logic [16:0]];
  int rd_age = 0;
  int hold_cnt = 0;
  int wl_cnt = 0;
  bit wl_ok = 1'b1;
  logic [16:0] wl_addr;
  logic [15:0] wl_data;
  int cyc = 0;
  int last_start = -1;
  logic cs_prev = 1'b1;

  function automatic logic [15:0] mdl_get(input logic [16:0] a);
    if (mdl_mem.exists(a)) return mdl_mem[a];
    return 16'h0000;
  endfunction

  function automatic logic [15:0] exp_get(input logic [16:0] a);
    if (exp_mem.exists(a)) return exp_mem[a];
    return 16'h0000;
  endfunction

  always @* begin
    logic [15:0] cur;
    cur = mdl_get(mem_addr);
    for (int l = 0; l < 2; l++) begin
      if (!mem_cs_n && !mem_oe_n && mem_we_n && !mem_lane_n[l] && rd_age >= RD_CYC)
        mem_dq_in[l*8 +: 8] = cur[l*8 +: 8];
      else
        mem_dq_in[l*8 +: 8] = 8'h5A;
    end
  end

  always @(negedge clk) begin
    bit drive_now;
    logic [15:0] w;
    if (rst_n) begin
      cyc++;
      if (!mem_cs_n && cs_prev) begin
        if (last_start >= 0)
          check(cyc - last_start >= WC_CYC, "R4", "cycles between selects",
                cyc - last_start, WC_CYC);
        last_start = cyc;
      end
      cs_prev = mem_cs_n;

      if (!mem_we_n) begin
        if (wl_cnt == 0) begin
          wl_addr = mem_addr;
          wl_data = mem_dq_out;
          wl_ok   = 1'b1;
        end else if (mem_addr != wl_addr || mem_dq_out != wl_data) begin
          wl_ok = 1'b0;
        end
        if (!mem_dq_oe || mem_cs_n || !mem_oe_n) wl_ok = 1'b0;
        wl_cnt++;
        w = mdl_get(mem_addr);
        for (int l = 0; l < 2; l++)
          if (!mem_lane_n[l]) w[l*8 +: 8] = mem_dq_out[l*8 +: 8];
        mdl_mem[mem_addr] = w;
      end else if (wl_cnt > 0) begin
        check(wl_cnt == WR_CYC && wl_ok, "R3", "write pulse cycles/stability",
              wl_cnt, WR_CYC);
        wl_cnt = 0;
      end

      if (!mem_cs_n && !mem_oe_n && mem_we_n) rd_age++;
      else rd_age = 0;

      drive_now = !mem_cs_n && !mem_oe_n && mem_we_n;
      if ((drive_now || hold_cnt > 0) && mem_dq_oe) begin
        errors++;
        checks++;
        $display("FAIL R6 bus fight: actual=%0h expected=%0h", mem_dq_oe, 1'b0);
      end
      if (drive_now) begin
        hold_cnt = HZ_CYC;
      end else if (hold_cnt > 0) begin
        hold_cnt--;
        if (hold_cnt == 0) checks++;
      end
    end
  end

  // ---------------- host tasks ----------------
  task automatic check_idle(input string req);
    check(req_ready && mem_cs_n && mem_oe_n && mem_we_n && mem_lane_n == 2'b11 && !mem_dq_oe,
          req, "idle lines",
          {req_ready, mem_cs_n, mem_oe_n, mem_we_n, mem_lane_n, mem_dq_oe}, 7'b1111110);
  endtask

  task automatic issue(input bit wr, input logic [16:0] a, input logic [15:0] d,
                       input logic [1:0] m, output int busy, output int rsp_at,
                       output int rsp_n, output logic [15:0] rdat);
    int n;
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = a;
    req_wdata = d;
    req_mask  = m;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    n = 1;
    rsp_at = -1;
    rsp_n = 0;
    rdat = 16'h0;
    while (!req_ready) begin
      if (rsp_valid) begin rsp_at = n; rsp_n++; rdat = rsp_rdata; end
      @(negedge clk);
      n++;
    end
    if (rsp_valid) begin rsp_at = n; rsp_n++; rdat = rsp_rdata; end
    busy = n - 1;
  endtask

  task automatic do_write(input logic [16:0] a, input logic [15:0] d, input logic [1:0] m);
    int busy, rsp_at, rsp_n;
    logic [15:0] rdat;
    logic [15:0] e;
    issue(1'b1, a, d, m, busy, rsp_at, rsp_n, rdat);
    check(busy == WC_CYC, "R7", "write busy cycles", busy, WC_CYC);
    check_idle("R1");
    e = exp_get(a);
    if (m[0]) e[7:0]  = d[7:0];
    if (m[1]) e[15:8] = d[15:8];
    exp_mem[a] = e;
  endtask

  task automatic do_read(input logic [16:0] a, input logic [1:0] m);
    int busy, rsp_at, rsp_n;
    logic [15:0] rdat;
    logic [15:0] e;
    issue(1'b0, a, 16'h0, m, busy, rsp_at, rsp_n, rdat);
    e = exp_get(a);
    if (!m[0]) e[7:0]  = 8'h00;
    if (!m[1]) e[15:8] = 8'h00;
    check(rdat == e, "R2", "read data", rdat, e);
    check(rsp_at == RD_CYC + 1 && rsp_n == 1, "R5", "response timing", rsp_at, RD_CYC + 1);
    check(busy == RD_CYC + HZ_CYC, "R7", "read busy cycles", busy, RD_CYC + HZ_CYC);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [16:0] addrs [6];
    addrs[0] = 17'h00000;
    addrs[1] = 17'h00001;
    addrs[2] = 17'h1FFFF;
    addrs[3] = 17'h10000;
    addrs[4] = 17'h0AAAA;
    addrs[5] = 17'h15555;

    rst_n = 1'b0;
    req_valid = 1'b0;
    req_write = 1'b0;
    req_addr = '0;
    req_wdata = '0;
    req_mask = '0;
    repeat (3) @(negedge clk);
    check_idle("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1");

    for (int i = 0; i < 6; i++) begin
      logic [16:0] a;
      a = addrs[i];
      do_read(a, 2'b11);
      do_write(a, 16'(a * 37 + 16'h1234), 2'b11);
      do_read(a, 2'b11);
      for (int m = 0; m < 4; m++) begin
        do_write(a, 16'(a * 91 + m * 4099 + 16'h0F0F), 2'(m));
        for (int rm = 0; rm < 4; rm++) do_read(a, 2'(rm));
      end
    end

    // back-to-back: write right after read to different words
    do_write(17'h00002, 16'hBEEF, 2'b01);
    do_read(17'h00001, 2'b11);
    do_write(17'h00003, 16'hCAFE, 2'b10);
    do_read(17'h00002, 2'b11);
    do_read(17'h00003, 2'b11);

    // R8: reset during a write pulse
    req_valid = 1'b1;
    req_write = 1'b1;
    req_addr  = 17'h0F000;
    req_wdata = 16'h7777;
    req_mask  = 2'b11;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    check(!mem_we_n && mem_dq_oe, "R8", "write in progress", {mem_we_n, mem_dq_oe}, 2'b01);
    #2 rst_n = 1'b0;
    #1;
    check(mem_cs_n && mem_oe_n && mem_we_n && mem_lane_n == 2'b11 && !mem_dq_oe, "R8",
          "lines after async reset",
          {mem_cs_n, mem_oe_n, mem_we_n, mem_lane_n, mem_dq_oe}, 6'b111110);
    @(negedge clk);
    rst_n = 1'b1;
    wl_cnt = 0;
    hold_cnt = 0;
    last_start = -1;
    @(negedge clk);
    check_idle("R1");
    do_read(17'h1FFFF, 2'b11);

    finish_run();
  end

endmodule